// File: doc/BRIEF.md
# QPSK Symbol to OFDM Frequency-Bin Mapper

This block turns one data byte into one 64-bin frequency-domain frame, ready to feed a 64-point inverse FFT. The byte is split into four 2-bit groups. Each group becomes one four-point constellation symbol: one bit picks the sign of the real part and the other bit picks the sign of the imaginary part. The four symbols go on the four lowest positive subcarriers. Four fixed pilots sit at subcarriers -21, -7, +7 and +21. The DC bin, the band-edge guard bins and every other unused bin carry zero.

A byte is taken through a valid/ready handshake. Once a byte is accepted, the frame streams out one bin per clock in natural IFFT order, bin 0 to bin 63. A negative subcarrier k appears at bin 64+k. The output has no back-pressure. No new byte is taken until the last bin of the current frame has been sent.

Top module: `ofdm_bin_mapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `out_valid` is 1 for exactly 64 consecutive cycles. During those cycles `out_bin` counts 0 to 63, and `out_last` is 1 only when `out_bin` is 63.
- R3: `in_ready` is 0 for the whole time a frame is streaming. Any `in_valid` or `in_byte` activity during that time leaves the frame's values unchanged.
- R4: In a data bin, the first (more significant) bit of the pair sets the real part: 1 gives +AMP and 0 gives -AMP.
- R5: In a data bin, the second (less significant) bit of the pair sets the imaginary part: 1 gives +AMP and 0 gives -AMP.
- R6: Pairs are taken most significant first. Bits 7:6 go to bin 1, bits 5:4 to bin 2, bits 3:2 to bin 3 and bits 1:0 to bin 4.
- R7: Bins 7, 21, 43 and 57 (subcarriers +7, +21, -21 and -7) carry the pilot (+AMP, 0).
- R8: Bin 0 (DC) is always (0, 0).
- R9: All other bins are (0, 0). This includes the eleven guard bins 27 to 37.
- R10: If `in_valid` is still high when a frame ends, `in_ready` returns to 1 in the cycle after bin 63. The waiting byte is accepted on that edge, and its frame starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A data byte is offered |
| in_ready | output | 1 | The block can accept a byte |
| in_byte | input | 8 | Data byte |
| out_valid | output | 1 | A bin is present on the outputs |
| out_bin | output | 6 | Bin index, 0 to 63 |
| out_i | output | 16 | Real part of the bin, signed |
| out_q | output | 16 | Imaginary part of the bin, signed |
| out_last | output | 1 | Marks bin 63 |

## Verification
Two events can meet in the same cycle: the end of a frame and a new byte that is already waiting.

To provoke this, the bench raises `in_valid` with a second byte while the first frame is only a few bins in. It then holds `in_valid` high through the final bin. The result is judged on four points:
- `in_ready` stays low for all 64 bins.
- The first frame's data bins still match the first byte.
- `in_ready` rises in the cycle right after bin 63.
- The second frame begins one cycle later, with bins that match the second byte.

// File: rtl/obm_pkg.sv
// Package: shared sample type and subcarrier-to-bin helper for the bin mapper.
// Assumes two's-complement samples and a power-of-two frame length.
package obm_pkg;
    localparam int SAMP_W = 16;

    typedef struct packed {
        logic signed [SAMP_W-1:0] re;
        logic signed [SAMP_W-1:0] im;
    } cplx_t;

    // Map a signed subcarrier number onto its natural-order IFFT bin.
    function automatic int sub_to_bin(input int sub, input int nbins);
        return (sub < 0) ? (nbins + sub) : sub;
    endfunction
endpackage

// File: rtl/obm_seq.sv
// Module: frame sequencer. It accepts one byte at a time and holds it, then
// walks the bin counter from 0 to NBINS-1. It stays not-ready until the frame is done.
// Assumes the output side never stalls.
module obm_seq #(
    parameter int NBINS  = 64,
    parameter int BYTE_W = 8,
    localparam int IDX_W = $clog2(NBINS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              busy,
    output logic [IDX_W-1:0]  bin_idx,
    output logic              last,
    output logic [BYTE_W-1:0] byte_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBINS - 1);

    logic accept;

    assign in_ready = ~busy;
    assign accept   = in_valid & in_ready;
    assign last     = busy & (bin_idx == LAST_IDX);

    // Control state: start a frame on accept, count bins, stop after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bin_idx <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            bin_idx <= '0;
        end else if (busy) begin
            bin_idx <= bin_idx + 1'b1;
            if (bin_idx == LAST_IDX) busy <= 1'b0;
        end
    end

    // Data hold: capture the byte only on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      byte_q <= '0;
        else if (accept) byte_q <= in_byte;
    end

    // The counter steps by exactly one while a frame runs.
    assert_bin_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bin_idx != LAST_IDX) |=> (busy && bin_idx == $past(bin_idx) + 1'b1));
    // An accepted byte starts the frame at bin 0.
    assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (busy && bin_idx == '0));
    // The held byte cannot change while its frame is streaming.
    assert_byte_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(byte_q));
endmodule

// File: rtl/obm_qpsk_map.sv
// Module: sign-bit QPSK mapper. It turns a byte into BYTE_W/2 symbols.
// Symbol 0 takes the most significant pair. In each pair, the upper bit sets
// the real sign and the lower bit sets the imaginary sign. A set bit means +AMP.
module obm_qpsk_map
    import obm_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic signed [SAMP_W-1:0] AMP = 16'sd8192,
    localparam int NSYM = BYTE_W / 2
) (
    input  logic [BYTE_W-1:0] byte_in,
    output cplx_t [NSYM-1:0]  sym
);
    localparam logic signed [SAMP_W-1:0] NAMP = -AMP;

    for (genvar g = 0; g < NSYM; g++) begin : g_sym
        localparam int HI = BYTE_W - 1 - 2*g;
        // Per-symbol sign selection from its bit pair.
        always_comb begin
            sym[g].re = byte_in[HI]     ? AMP : NAMP;
            sym[g].im = byte_in[HI - 1] ? AMP : NAMP;
        end
    end
endmodule

// File: rtl/obm_bin_alloc.sv
// Module: subcarrier allocator. For a given bin index it picks a data symbol,
// a pilot, or zero. Data goes on subcarriers +1..+NSYM and pilots on +/-7 and +/-21.
// Assumes NBINS is large enough to hold every pilot subcarrier.
module obm_bin_alloc
    import obm_pkg::*;
#(
    parameter int NBINS = 64,
    parameter int NSYM  = 4,
    parameter logic signed [SAMP_W-1:0] AMP = 16'sd8192,
    localparam int IDX_W = $clog2(NBINS)
) (
    input  logic [IDX_W-1:0] bin_idx,
    input  cplx_t [NSYM-1:0] sym,
    output cplx_t            bin_val
);
    localparam int NPIL = 4;
    localparam int PIL_SUB [NPIL] = '{-21, -7, 7, 21};

    logic [NPIL-1:0] pil_hit;
    logic [NSYM-1:0] dat_hit;

    for (genvar p = 0; p < NPIL; p++) begin : g_pil
        assign pil_hit[p] = (bin_idx == IDX_W'(sub_to_bin(PIL_SUB[p], NBINS)));
    end
    for (genvar d = 0; d < NSYM; d++) begin : g_dat
        assign dat_hit[d] = (bin_idx == IDX_W'(d + 1));
    end

    // Select the bin content; anything not data or pilot stays zero.
    always_comb begin
        bin_val = '0;
        if (|pil_hit) begin
            bin_val.re = AMP;
            bin_val.im = '0;
        end
        for (int d = 0; d < NSYM; d++) begin
            if (dat_hit[d]) bin_val = sym[d];
        end
    end

    // Pilot and data positions never overlap.
    assert_no_overlap_R7: assert property (@(bin_idx) !((|pil_hit) && (|dat_hit)));
endmodule

// File: rtl/ofdm_bin_mapper.sv
// Module: top of the QPSK-to-OFDM bin mapper. It takes one byte and streams
// one NBINS-bin frame, one bin per clock in natural order.
// Assumes a synchronous active-low reset and a downstream that never stalls.
module ofdm_bin_mapper
    import obm_pkg::*;
#(
    parameter int NBINS  = 64,
    parameter int BYTE_W = 8,
    parameter logic signed [SAMP_W-1:0] AMP = 16'sd8192,
    localparam int IDX_W = $clog2(NBINS),
    localparam int NSYM  = BYTE_W / 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [BYTE_W-1:0]        in_byte,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_bin,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_last
);
    logic              busy;
    logic [IDX_W-1:0]  bin_idx;
    logic              last;
    logic [BYTE_W-1:0] byte_q;
    cplx_t [NSYM-1:0]  sym;
    cplx_t             bin_val;

    obm_seq #(.NBINS(NBINS), .BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .busy(busy), .bin_idx(bin_idx), .last(last),
        .byte_q(byte_q)
    );

    obm_qpsk_map #(.BYTE_W(BYTE_W), .AMP(AMP)) u_map (
        .byte_in(byte_q), .sym(sym)
    );

    obm_bin_alloc #(.NBINS(NBINS), .NSYM(NSYM), .AMP(AMP)) u_alloc (
        .bin_idx(bin_idx), .sym(sym), .bin_val(bin_val)
    );

    assign out_valid = busy;
    assign out_bin   = bin_idx;
    assign out_i     = bin_val.re;
    assign out_q     = bin_val.im;
    assign out_last  = last;

    // DC never carries energy.
    assert_dc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == '0) |-> (out_i == '0 && out_q == '0));
    // The +7 pilot is real and positive.
    assert_pilot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == IDX_W'(7)) |-> (out_i == AMP && out_q == '0));
    // The first data bin follows the top bit pair of the held byte.
    assert_first_sym_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == IDX_W'(1)) |->
        (out_i == (byte_q[BYTE_W-1] ? AMP : -AMP) && out_q == (byte_q[BYTE_W-2] ? AMP : -AMP)));
    // The most negative subcarrier is a guard bin.
    assert_guard_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bin == IDX_W'(NBINS/2)) |-> (out_i == '0 && out_q == '0));
    // No byte is offered as accepted while a frame streams.
    assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/sim_ofdm_bin_mapper.sv
// Bench: directed scenarios. Each task checks its own results at falling edges.
module sim_ofdm_bin_mapper;
    localparam int CLK_PERIOD = 10;
    localparam logic signed [15:0] A = 16'sd8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = '0;
    logic in_ready, out_valid, out_last;
    logic [5:0] out_bin;
    logic signed [15:0] out_i, out_q;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofdm_bin_mapper #(.AMP(A)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .out_valid(out_valid), .out_bin(out_bin),
        .out_i(out_i), .out_q(out_q), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_re(input int bin, input logic [7:0] b);
        if (bin >= 1 && bin <= 4) return b[9 - 2*bin] ? int'(A) : -int'(A);
        if (bin == 7 || bin == 21 || bin == 43 || bin == 57) return int'(A);
        return 0;
    endfunction

    function automatic int exp_im(input int bin, input logic [7:0] b);
        if (bin >= 1 && bin <= 4) return b[8 - 2*bin] ? int'(A) : -int'(A);
        return 0;
    endfunction

    function automatic string bin_tag(input int bin, input bit imag);
        if (bin == 0) return "R8";
        if (bin >= 1 && bin <= 4) return imag ? "R5 R6" : "R4 R6";
        if (bin == 7 || bin == 21 || bin == 43 || bin == 57) return "R7";
        return "R9";
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    endtask

    // Offer a byte and let the accepting edge pass.
    task automatic offer(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte = b;
        chk(in_ready == 1'b1, "R2 ready before accept", int'(in_ready), 1);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Check all 64 bins of a frame. If spoil is set, offer a new byte midway and leave it waiting.
    task automatic sweep(input logic [7:0] b, input bit spoil, input logic [7:0] sb);
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (spoil && k == 5) begin
                in_valid = 1'b1;
                in_byte = sb;
            end
            chk(out_valid == 1'b1, "R2 out_valid in frame", int'(out_valid), 1);
            chk(out_bin == 6'(k), "R2 bin order", int'(out_bin), k);
            chk(out_last == (k == 63), "R2 out_last", int'(out_last), int'(k == 63));
            chk(in_ready == 1'b0, "R3 ready low in frame", int'(in_ready), 0);
            chk(int'(out_i) == exp_re(k, b), bin_tag(k, 1'b0), int'(out_i), exp_re(k, b));
            chk(int'(out_q) == exp_im(k, b), bin_tag(k, 1'b1), int'(out_q), exp_im(k, b));
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 frame length 64", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R10 ready after last bin", int'(in_ready), 1);
    endtask

    task automatic t_single(input logic [7:0] b);
        offer(b);
        sweep(b, 1'b0, 8'h00);
    endtask

    task automatic t_back_to_back(input logic [7:0] b1, input logic [7:0] b2);
        offer(b1);
        sweep(b1, 1'b1, b2);   // b2 waits: R3 ignore, then R10 accept
        @(posedge clk);
        #1 in_valid = 1'b0;
        sweep(b2, 1'b0, 8'h00);
    endtask

    initial begin
        t_reset();
        t_single(8'b11_10_01_00);   // R6: a distinct pair on each bin
        t_single(8'h00);            // R4 R5: all negative
        t_single(8'hFF);            // R4 R5: all positive
        t_single(8'b01_10_10_01);
        t_back_to_back(8'hA5, 8'h3C);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule